// File: doc/BRIEF.md
# SCSI Command Descriptor Decoder

This block turns one command descriptor, up to ten bytes long, into the results a storage controller needs to run the command. It also takes a target select byte, and the low three bits of that byte choose the target. A per-target presence bitmap and a per-target media bitmap say which targets exist and which of them hold optical media.

From these inputs the block decides four things:
- whether the target answers;
- which operation is requested;
- the block address and block count, for the read and write commands;
- the byte length and direction of the data phase.

It then forms the status, interrupt and sequence-step codes that the controller latches.

The interface is control-level, with no stream handshake. A one-cycle `start` pulse presents a descriptor. Exactly two cycles later a one-cycle `done` pulse marks the outputs as the result. Starts may arrive on every cycle, and each start produces its own `done`, in order. No back-pressure exists, so the controller must take each result in the cycle its `done` is high. Between results the outputs keep their last values.

Top module: `cdb_decoder`

## Requirements
- R1: A `start` sampled high at a rising edge yields `done` high for exactly one cycle, after the second rising edge that follows it. Starts on consecutive cycles yield consecutive `done` pulses in the same order. While `done` is low, every result output keeps its previous value.
- R2: The target ID is `tgt_sel[2:0]`, and `tgt_sel[7:3]` has no effect. A target is absent if its ID is 4 or above, or if its bit in `tgt_present` is 0. For an absent target the result is status 0x80, interrupt 0x20 and sequence step 0x00, with length 0, direction 0, address 0, count 0 and capacity code 0, whatever the opcode.
- R3: Descriptor byte i sits at `cdb[8*i+7:8*i]`, and byte 0 is the opcode.
- R4: Every command to a present target completes with status 0x91, interrupt 0x18 and sequence step 0x04.
- R5: Opcode 0x12 (inquiry) gives length 36 and direction 1 (device to host).
- R6: Opcode 0x25 (read capacity) gives length 8 and direction 1. Its capacity code is 2 for a disk and 8 for an optical target (`tgt_optical` bit set).
- R7: Opcode 0x28 (read) takes the address from bytes 2..5 (byte 2 most significant) and the count from bytes 7..8 (byte 7 most significant). On a disk it outputs that address and count unchanged, with length count*512 and direction 1.
- R8: On an optical target, reads and writes output the address times 4 and the count times 4, with length count*8192 (four times the count, in 2048-byte sectors).
- R9: Opcode 0x2A (write) decodes its fields like a read, but with direction 0.
- R10: Any other opcode sent to a present target, including 0x00 and 0x1A, gives length 0, direction 0, address 0, count 0 and capacity code 0. Descriptor bytes 1, 6 and 9 never affect any output.
- R11: While reset is active, and after it, until the first `done`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Presents a descriptor for decoding |
| tgt_sel | input | 8 | Select byte; the low 3 bits are the target ID |
| cdb | input | 80 | Descriptor bytes, byte i at bits 8i+7:8i |
| tgt_present | input | 8 | One bit per target ID: a device is present |
| tgt_optical | input | 8 | One bit per target ID: the media is optical |
| done | output | 1 | One-cycle strobe marking a fresh result |
| status | output | 8 | Status code |
| intr | output | 8 | Interrupt code |
| seq_step | output | 8 | Sequence step code |
| dir_to_host | output | 1 | 1: data flows device to host; 0: host to device or no data |
| lba | output | 34 | Scaled block address |
| blk_cnt | output | 18 | Scaled block count |
| xfer_len | output | 32 | Data phase length in bytes |
| cap_size_code | output | 8 | Sector-size code for read capacity |

## Verification
Every result is due on the second rising edge after the edge that samples `start`. The bench drives its inputs on falling edges, stamps each expected result with a due cycle two counts past the current one, and samples on the next falling edges. On a due cycle it compares `done` and every result output against the reference. On every other cycle it checks that `done` is low and that the outputs still match the last result, so a result that arrives early, arrives late or drifts is reported in the cycle it happens.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int BYTE_W        = 8;
  localparam int ADDR_W        = 32;
  localparam int COUNT_W       = 16;
  localparam int MEDIA_SCALE_L2 = 2;
  localparam int DISK_SECT_L2  = 9;
  localparam int OPT_SECT_L2   = 11;

  localparam logic [7:0] OP_TEST_READY = 8'h00;
  localparam logic [7:0] OP_INQUIRY    = 8'h12;
  localparam logic [7:0] OP_MODE_SENSE = 8'h1A;
  localparam logic [7:0] OP_READ_CAP   = 8'h25;
  localparam logic [7:0] OP_READ10     = 8'h28;
  localparam logic [7:0] OP_WRITE10    = 8'h2A;

  localparam logic [7:0] ST_DONE   = 8'h91;
  localparam logic [7:0] ST_ABSENT = 8'h80;
  localparam logic [7:0] IR_DONE   = 8'h18;
  localparam logic [7:0] IR_DISC   = 8'h20;
  localparam logic [7:0] SQ_DONE   = 8'h04;
  localparam logic [7:0] SQ_IDLE   = 8'h00;

  localparam int INQ_LEN = 36;
  localparam int CAP_LEN = 8;
  localparam logic [7:0] CAP_CODE_DISK = 8'd2;
  localparam logic [7:0] CAP_CODE_OPT  = 8'd8;

  typedef enum logic [2:0] {
    K_OTHER, K_INQUIRY, K_READ_CAP, K_READ, K_WRITE
  } op_kind_e;

  typedef struct packed {
    logic                present;
    logic                optical;
    op_kind_e            kind;
    logic [ADDR_W-1:0]   addr;
    logic [COUNT_W-1:0]  count;
  } dec_t;
endpackage

// File: rtl/cdb_field_extract.sv
module cdb_field_extract
  import cdb_pkg::*;
#(
  parameter int CDB_BYTES = 10,
  parameter int NUM_TGT   = 8,
  parameter int MAX_TGT   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [7:0]                    tgt_sel,
  input  logic [CDB_BYTES*BYTE_W-1:0]   cdb,
  input  logic [NUM_TGT-1:0]            tgt_present,
  input  logic [NUM_TGT-1:0]            tgt_optical,
  output logic                          s1_valid,
  output dec_t                          s1_dec
);
  localparam int ID_W = $clog2(NUM_TGT);

  logic [BYTE_W-1:0] byte_a [CDB_BYTES];
  for (genvar gi = 0; gi < CDB_BYTES; gi++) begin : g_unpack
    assign byte_a[gi] = cdb[gi*BYTE_W +: BYTE_W];
  end

  logic [ID_W-1:0] id;
  logic            present_c;
  op_kind_e        kind_c;

  assign id        = tgt_sel[ID_W-1:0];
  assign present_c = (int'(id) < MAX_TGT) && tgt_present[id];

  always_comb begin
    unique case (byte_a[0])
      OP_INQUIRY:  kind_c = K_INQUIRY;
      OP_READ_CAP: kind_c = K_READ_CAP;
      OP_READ10:   kind_c = K_READ;
      OP_WRITE10:  kind_c = K_WRITE;
      default:     kind_c = K_OTHER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_dec   <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_dec.present <= present_c;
        s1_dec.optical <= tgt_optical[id];
        s1_dec.kind    <= kind_c;
        s1_dec.addr    <= {byte_a[2], byte_a[3], byte_a[4], byte_a[5]};
        s1_dec.count   <= {byte_a[7], byte_a[8]};
      end
    end
  end

  a_r1_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> s1_valid);
endmodule

// File: rtl/cdb_completion.sv
module cdb_completion
  import cdb_pkg::*;
#(
  parameter int LBA_W = ADDR_W + MEDIA_SCALE_L2,
  parameter int CNT_W = COUNT_W + MEDIA_SCALE_L2,
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  dec_t             s1_dec,
  output logic             done,
  output logic [7:0]       status,
  output logic [7:0]       intr,
  output logic [7:0]       seq_step,
  output logic             dir_to_host,
  output logic [LBA_W-1:0] lba,
  output logic [CNT_W-1:0] blk_cnt,
  output logic [LEN_W-1:0] xfer_len,
  output logic [7:0]       cap_size_code
);
  localparam int OPT_LEN_L2 = OPT_SECT_L2 + MEDIA_SCALE_L2;

  logic [LBA_W-1:0] lba_c;
  logic [CNT_W-1:0] cnt_c;
  logic [LEN_W-1:0] len_rw, len_c;
  logic [7:0]       st_c, ir_c, sq_c, cap_c;
  logic             dir_c;

  always_comb begin
    if (s1_dec.optical) begin
      lba_c  = LBA_W'(s1_dec.addr)  << MEDIA_SCALE_L2;
      cnt_c  = CNT_W'(s1_dec.count) << MEDIA_SCALE_L2;
      len_rw = LEN_W'(s1_dec.count) << OPT_LEN_L2;
    end else begin
      lba_c  = LBA_W'(s1_dec.addr);
      cnt_c  = CNT_W'(s1_dec.count);
      len_rw = LEN_W'(s1_dec.count) << DISK_SECT_L2;
    end
  end

  always_comb begin
    st_c  = ST_DONE;
    ir_c  = IR_DONE;
    sq_c  = SQ_DONE;
    dir_c = 1'b0;
    len_c = '0;
    cap_c = '0;
    if (!s1_dec.present) begin
      st_c = ST_ABSENT;
      ir_c = IR_DISC;
      sq_c = SQ_IDLE;
    end else begin
      unique case (s1_dec.kind)
        K_INQUIRY: begin
          dir_c = 1'b1;
          len_c = LEN_W'(INQ_LEN);
        end
        K_READ_CAP: begin
          dir_c = 1'b1;
          len_c = LEN_W'(CAP_LEN);
          cap_c = s1_dec.optical ? CAP_CODE_OPT : CAP_CODE_DISK;
        end
        K_READ: begin
          dir_c = 1'b1;
          len_c = len_rw;
        end
        K_WRITE: len_c = len_rw;
        default: ;
      endcase
    end
  end

  logic rw_c;
  assign rw_c = s1_dec.present && (s1_dec.kind == K_READ || s1_dec.kind == K_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done          <= 1'b0;
      status        <= '0;
      intr          <= '0;
      seq_step      <= '0;
      dir_to_host   <= 1'b0;
      lba           <= '0;
      blk_cnt       <= '0;
      xfer_len      <= '0;
      cap_size_code <= '0;
    end else begin
      done <= s1_valid;
      if (s1_valid) begin
        status        <= st_c;
        intr          <= ir_c;
        seq_step      <= sq_c;
        dir_to_host   <= dir_c;
        xfer_len      <= len_c;
        cap_size_code <= cap_c;
        lba           <= rw_c ? lba_c : '0;
        blk_cnt       <= rw_c ? cnt_c : '0;
      end
    end
  end

  a_r1_result_due: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> done);
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(status) && $stable(xfer_len) && $stable(lba)));
endmodule

// File: rtl/cdb_decoder.sv
module cdb_decoder
  import cdb_pkg::*;
#(
  parameter int CDB_BYTES = 10,
  parameter int NUM_TGT   = 8,
  parameter int MAX_TGT   = 4,
  parameter int LBA_W     = ADDR_W + MEDIA_SCALE_L2,
  parameter int CNT_W     = COUNT_W + MEDIA_SCALE_L2,
  parameter int LEN_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [7:0]                  tgt_sel,
  input  logic [CDB_BYTES*BYTE_W-1:0] cdb,
  input  logic [NUM_TGT-1:0]          tgt_present,
  input  logic [NUM_TGT-1:0]          tgt_optical,
  output logic                        done,
  output logic [7:0]                  status,
  output logic [7:0]                  intr,
  output logic [7:0]                  seq_step,
  output logic                        dir_to_host,
  output logic [LBA_W-1:0]            lba,
  output logic [CNT_W-1:0]            blk_cnt,
  output logic [LEN_W-1:0]            xfer_len,
  output logic [7:0]                  cap_size_code
);
  logic s1_valid;
  dec_t s1_dec;

  cdb_field_extract #(
    .CDB_BYTES(CDB_BYTES), .NUM_TGT(NUM_TGT), .MAX_TGT(MAX_TGT)
  ) u_extract (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_sel(tgt_sel), .cdb(cdb),
    .tgt_present(tgt_present), .tgt_optical(tgt_optical),
    .s1_valid(s1_valid), .s1_dec(s1_dec)
  );

  cdb_completion #(
    .LBA_W(LBA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_complete (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_dec(s1_dec),
    .done(done), .status(status), .intr(intr), .seq_step(seq_step),
    .dir_to_host(dir_to_host), .lba(lba), .blk_cnt(blk_cnt),
    .xfer_len(xfer_len), .cap_size_code(cap_size_code)
  );

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);
  a_r2_absent_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_ABSENT) |-> (intr == IR_DISC && seq_step == SQ_IDLE
                                       && xfer_len == '0 && !dir_to_host));
  a_r4_success_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_DONE) |-> (intr == IR_DONE && seq_step == SQ_DONE));
  a_r7_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (xfer_len[8:0] == '0 || xfer_len == LEN_W'(INQ_LEN)
              || xfer_len == LEN_W'(CAP_LEN)));
endmodule

// File: tb/cdb_decoder_tb.sv
`timescale 1ns/1ps
module cdb_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  tgt_sel = '0;
  logic [79:0] cdb = '0;
  logic [7:0]  tgt_present = 8'b0000_1011;
  logic [7:0]  tgt_optical = 8'b0000_1000;
  logic        done;
  logic [7:0]  status, intr, seq_step, cap_size_code;
  logic        dir_to_host;
  logic [33:0] lba;
  logic [17:0] blk_cnt;
  logic [31:0] xfer_len;

  always #2.5 clk = ~clk;

  cdb_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_sel(tgt_sel), .cdb(cdb),
    .tgt_present(tgt_present), .tgt_optical(tgt_optical), .done(done),
    .status(status), .intr(intr), .seq_step(seq_step),
    .dir_to_host(dir_to_host), .lba(lba), .blk_cnt(blk_cnt),
    .xfer_len(xfer_len), .cap_size_code(cap_size_code)
  );

  typedef struct {
    int          due;
    string       tag;
    logic [7:0]  st, it, sq, cap;
    logic        dir;
    logic [33:0] lba;
    logic [17:0] cnt;
    logic [31:0] len;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   checking = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(input logic [7:0] sel, input logic [7:0] op,
                                 input logic [31:0] a, input logic [15:0] n,
                                 input string tag);
    exp_t e;
    int   id;
    bit   opt;
    e = '{due: 0, tag: tag, st: 8'h80, it: 8'h20, sq: 8'h00, cap: 8'h00,
          dir: 1'b0, lba: '0, cnt: '0, len: '0};
    id  = int'(sel[2:0]);
    opt = tgt_optical[id];
    if (id >= 4 || !tgt_present[id]) return e;
    e.st = 8'h91; e.it = 8'h18; e.sq = 8'h04;
    case (op)
      8'h12: begin e.len = 36; e.dir = 1'b1; end
      8'h25: begin e.len = 8; e.dir = 1'b1; e.cap = opt ? 8'd8 : 8'd2; end
      8'h28, 8'h2A: begin
        longint la, lc, ll;
        la = opt ? longint'(a) * 4 : longint'(a);
        lc = opt ? longint'(n) * 4 : longint'(n);
        ll = opt ? longint'(n) * 8192 : longint'(n) * 512;
        e.lba = la[33:0]; e.cnt = lc[17:0]; e.len = ll[31:0];
        e.dir = (op == 8'h28);
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [7:0] sel, input logic [7:0] op,
                       input logic [31:0] a, input logic [15:0] n,
                       input string tag);
    exp_t e;
    @(negedge clk);
    start   = 1'b1;
    tgt_sel = sel;
    cdb     = '0;
    cdb[7:0]   = op;
    cdb[15:8]  = 8'hA5;
    cdb[23:16] = a[31:24];
    cdb[31:24] = a[23:16];
    cdb[39:32] = a[15:8];
    cdb[47:40] = a[7:0];
    cdb[55:48] = 8'h3C;
    cdb[63:56] = n[15:8];
    cdb[71:64] = n[7:0];
    cdb[79:72] = 8'h77;
    e = model(sel, op, a, n, tag);
    e.due = cyc + 2;
    q.push_back(e);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      start = 1'b0;
      cdb   = {10{8'hEE}};
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      exp_t e;
      bit   due_now;
      due_now = (q.size() > 0) && (q[0].due == cyc);
      if (due_now) begin
        e = q.pop_front();
        last = e;
      end else begin
        e = last;
        e.tag = "R1";
      end
      checks++;
      if (done !== due_now || status !== e.st || intr !== e.it ||
          seq_step !== e.sq || dir_to_host !== e.dir || lba !== e.lba ||
          blk_cnt !== e.cnt || xfer_len !== e.len || cap_size_code !== e.cap) begin
        fails++;
        $display("FAIL %s cyc=%0d actual done=%b st=%h it=%h sq=%h dir=%b lba=%h cnt=%h len=%h cap=%h expected done=%b st=%h it=%h sq=%h dir=%b lba=%h cnt=%h len=%h cap=%h",
                 e.tag, cyc, done, status, intr, seq_step, dir_to_host, lba,
                 blk_cnt, xfer_len, cap_size_code, due_now, e.st, e.it, e.sq,
                 e.dir, e.lba, e.cnt, e.len, e.cap);
      end
    end
  end

  initial begin
    last = '{due: 0, tag: "R11", st: 0, it: 0, sq: 0, cap: 0, dir: 0,
             lba: 0, cnt: 0, len: 0};
    repeat (3) @(negedge clk);
    // R11: outputs zero during reset
    checks++;
    if (done !== 0 || status !== 0 || xfer_len !== 0 || lba !== 0) begin
      fails++;
      $display("FAIL R11 actual done=%b st=%h len=%h expected all zero",
               done, status, xfer_len);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checking = 1;
    idle(2);
    // R5, R3: inquiry to disk target 0
    issue(8'h00, 8'h12, 32'h0, 16'h0, "R5");
    idle(3);
    // R6: read capacity disk and optical
    issue(8'h01, 8'h25, 32'h0, 16'h0, "R6");
    issue(8'h03, 8'h25, 32'h0, 16'h0, "R6");
    idle(3);
    // R7: disk read
    issue(8'h00, 8'h28, 32'h0012_3456, 16'h0010, "R7");
    // R8: optical read, max fields
    issue(8'h03, 8'h28, 32'hFFFF_FFFF, 16'hFFFF, "R8");
    // R9: disk write then optical write
    issue(8'h01, 8'h2A, 32'hDEAD_BEEF, 16'h0102, "R9");
    issue(8'h03, 8'h2A, 32'h0000_1000, 16'h0003, "R8");
    idle(4);
    // R2: absent targets: ID out of range, present bit clear; upper select bits ignored
    issue(8'h05, 8'h28, 32'h1, 16'h1, "R2");
    issue(8'h02, 8'h12, 32'h0, 16'h0, "R2");
    issue(8'hF9, 8'h12, 32'h0, 16'h0, "R2");
    idle(3);
    // R10: other opcodes, completion codes R4
    issue(8'h00, 8'h00, 32'h1234_5678, 16'h9999, "R10");
    issue(8'h01, 8'h1A, 32'h1234_5678, 16'h9999, "R10");
    issue(8'h03, 8'h55, 32'h1234_5678, 16'h9999, "R4");
    idle(5);
    // R1: back-to-back starts then long gap
    for (int i = 0; i < 6; i++)
      issue(8'(i % 4), (i % 2) ? 8'h28 : 8'h2A, 32'(i * 17), 16'(i + 1), "R1");
    idle(8);
    checking = 0;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1 actual %0d results missing expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 5000);
    fails++;
    $display("FAIL R1 watchdog expired actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule